// File: doc/BRIEF.md
# Exception Entry Sequencer

This block walks a processor core through exception entry once the core has accepted an exception. When a request is taken, the sequencer keeps an internal copy of the status register before anything changes it. It then picks the supervisor stack the frame belongs on and pushes a two-word frame through a simple memory-write port. It ends with the new status register, the new stack pointer and the address from which the handler vector must be fetched, all marked by a one-cycle done pulse.

There are two supervisor stacks. A stack-mode bit in the status register chooses between them. A task exception taken while that bit is set goes onto the per-task master stack. An interrupt clears the bit and goes onto the interrupt stack. Any other exception also goes onto the interrupt stack. The core loads the returned status and stack pointer into its own registers and fetches the vector from the returned address. Prioritisation between exceptions and the real bus protocol belong to the surrounding core.

Top module: `exc_entry_seq`

## Requirements
- R1: While reset is held and after its release, `req_ready` is 1 and `wr_en` and `done` are 0. `sr_out`, `sp_out`, `sp_sel_out` and `vec_addr` are all 0.
- R2: A request is taken on a clock edge where `req_valid` and `req_ready` are both 1. `req_ready` stays 0 from the cycle after acceptance up to and including the done cycle. Requests and input changes during that time have no effect on the frame or on the results.
- R3: `wr_en` is 1 in exactly the two cycles that follow the acceptance edge, and 0 in the done cycle.
- R4: The stack-mode bit is status bit 12. A task exception (`req_is_irq`=0) with that bit set uses `msp_in`, and `sp_sel_out`=1. An interrupt, or a task exception with the bit clear, uses `isp_in`, and `sp_sel_out`=0.
- R5: The stack pointer is predecremented by 4 for each write. The first write goes to base-4 and the second to base-8, with arithmetic modulo 2^32.
- R6: The first word is {status as it was at acceptance, `req_pc[15:0]`}, with the status in bits 31:16.
- R7: The second word is {`req_pc[31:16]`, vector offset zero-extended into bits 15:0}, where the offset is the vector number times four.
- R8: `done` is a single-cycle pulse in the third cycle after acceptance. At that point `vec_addr` equals `vbr_in` plus the vector number times four, modulo 2^32.
- R9: At done, `sr_out` equals the captured status with bit 13 (supervisor) set. Bit 12 is cleared for an interrupt and kept for a task exception. All other bits, including the interrupt mask in bits 10:8, are unchanged.
- R10: At done, `sp_out` equals the selected base minus 8. `sr_out`, `sp_out`, `sp_sel_out` and `vec_addr` then hold until the next done.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous active-low reset |
| req_valid | input | 1 | Exception request present |
| req_ready | output | 1 | Sequencer idle, request can be taken |
| req_vector | input | 8 | Exception vector number |
| req_is_irq | input | 1 | 1 for an interrupt, 0 for a task exception |
| req_pc | input | 32 | Program counter to save |
| sr_in | input | 16 | Current status register |
| vbr_in | input | 32 | Vector base register |
| msp_in | input | 32 | Master stack pointer |
| isp_in | input | 32 | Interrupt stack pointer |
| wr_en | output | 1 | Stack write strobe |
| wr_addr | output | 32 | Stack write address |
| wr_data | output | 32 | Stack write data |
| sr_out | output | 16 | Status register after entry |
| sp_sel_out | output | 1 | 1 if the master stack was used |
| sp_out | output | 32 | Stack pointer after the frame |
| vec_addr | output | 32 | Vector fetch address |
| done | output | 1 | Entry complete, one cycle |

## Verification
The assertions take for granted that reset is held for at least one clock before any request, so that the comparisons against the previous cycle start from the idle state. They also assume that `req_valid` is never unknown. The request fields matter only on the acceptance edge, so the checks place no stability demand on them. The stimulus holds reset for several cycles and drives every input with defined values at the falling edge. While the sequencer is busy it deliberately keeps `req_valid` high and scrambles the other inputs, to show that these are ignored rather than merely absent.

// File: rtl/exc_pkg.sv
// Shared constants and types for the exception entry sequencer.
// Assumes a 16-bit status register and a 32-bit address space.
package exc_pkg;
    localparam int SR_W         = 16;
    localparam int ADDR_W       = 32;
    localparam int HALF_W       = ADDR_W / 2;
    localparam int SR_SUPER_BIT = 13;
    localparam int SR_MSTK_BIT  = 12;
    localparam int FRAME_STEP   = 4;

    typedef enum logic [1:0] {
        ST_IDLE  = 2'd0,
        ST_WR_HI = 2'd1,
        ST_WR_LO = 2'd2,
        ST_DONE  = 2'd3
    } seq_state_t;
endpackage

// File: rtl/exc_stack_sel.sv
// Chooses the supervisor stack for a new frame.
// Assumes: the stack-mode bit is sampled from the status before entry.
module exc_stack_sel
    import exc_pkg::*;
(
    input  logic              is_irq,
    input  logic              mstk_bit,
    input  logic [ADDR_W-1:0] msp,
    input  logic [ADDR_W-1:0] isp,
    output logic              use_msp,
    output logic [ADDR_W-1:0] sp_base
);
    // Master stack only for a task exception with the mode bit set.
    always_comb begin
        use_msp = !is_irq && mstk_bit;
        sp_base = use_msp ? msp : isp;
    end
endmodule

// File: rtl/exc_sr_update.sv
// Builds the status register that is in force after exception entry.
// Assumes: the input is the copy taken at acceptance, not the live status.
module exc_sr_update
    import exc_pkg::*;
(
    input  logic [SR_W-1:0] sr_copy,
    input  logic            is_irq,
    output logic [SR_W-1:0] sr_new
);
    // Force supervisor; an interrupt also drops the stack-mode bit.
    always_comb begin
        sr_new               = sr_copy;
        sr_new[SR_SUPER_BIT] = 1'b1;
        if (is_irq) begin
            sr_new[SR_MSTK_BIT] = 1'b0;
        end
    end
endmodule

// File: rtl/exc_vector_calc.sv
// Turns a vector number into a byte offset and a fetch address.
// Assumes: each vector slot is one 4-byte word; the address wraps at 2^32.
module exc_vector_calc
    import exc_pkg::*;
#(
    parameter int VEC_W = 8,
    localparam int OFF_W = VEC_W + 2
) (
    input  logic [VEC_W-1:0]  vec_num,
    input  logic [ADDR_W-1:0] vbr,
    output logic [OFF_W-1:0]  offset,
    output logic [ADDR_W-1:0] fetch_addr
);
    // Scale by four and add the table base.
    always_comb begin
        offset     = {vec_num, 2'b00};
        fetch_addr = vbr + ADDR_W'(offset);
    end
endmodule

// File: rtl/exc_frame_gen.sv
// Drives the stack write port for the two frame words.
// Assumes: the offset fits in half a word (VEC_W + 2 <= 16).
module exc_frame_gen
    import exc_pkg::*;
#(
    parameter int VEC_W = 8,
    localparam int OFF_W = VEC_W + 2
) (
    input  seq_state_t        state,
    input  logic [ADDR_W-1:0] sp_base,
    input  logic [SR_W-1:0]   sr_copy,
    input  logic [ADDR_W-1:0] pc,
    input  logic [OFF_W-1:0]  offset,
    output logic              wr_en,
    output logic [ADDR_W-1:0] wr_addr,
    output logic [ADDR_W-1:0] wr_data
);
    logic [HALF_W-1:0] off_ext;

    // Zero-extend the offset into the low half of the second word.
    always_comb off_ext = HALF_W'(offset);

    // Pick address and data for the write state in force.
    always_comb begin
        wr_en   = 1'b0;
        wr_addr = '0;
        wr_data = '0;
        case (state)
            ST_WR_HI: begin
                wr_en   = 1'b1;
                wr_addr = sp_base - ADDR_W'(FRAME_STEP);
                wr_data = {sr_copy, pc[HALF_W-1:0]};
            end
            ST_WR_LO: begin
                wr_en   = 1'b1;
                wr_addr = sp_base - ADDR_W'(2 * FRAME_STEP);
                wr_data = {pc[ADDR_W-1:HALF_W], off_ext};
            end
            default: ;
        endcase
    end
endmodule

// File: rtl/exc_entry_seq.sv
// Exception entry sequencer: captures status and request on acceptance,
// pushes a two-word frame, then presents new status, stack pointer and
// vector fetch address with a one-cycle done pulse.
// Assumes: request fields are valid on the acceptance edge only.
module exc_entry_seq
    import exc_pkg::*;
#(
    parameter int VEC_W = 8
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              req_valid,
    output logic              req_ready,
    input  logic [VEC_W-1:0]  req_vector,
    input  logic              req_is_irq,
    input  logic [ADDR_W-1:0] req_pc,
    input  logic [SR_W-1:0]   sr_in,
    input  logic [ADDR_W-1:0] vbr_in,
    input  logic [ADDR_W-1:0] msp_in,
    input  logic [ADDR_W-1:0] isp_in,
    output logic              wr_en,
    output logic [ADDR_W-1:0] wr_addr,
    output logic [ADDR_W-1:0] wr_data,
    output logic [SR_W-1:0]   sr_out,
    output logic              sp_sel_out,
    output logic [ADDR_W-1:0] sp_out,
    output logic [ADDR_W-1:0] vec_addr,
    output logic              done
);
    localparam int OFF_W = VEC_W + 2;

    seq_state_t        state_q;
    logic [SR_W-1:0]   sr_copy_q;
    logic [VEC_W-1:0]  vec_q;
    logic [ADDR_W-1:0] pc_q;
    logic [ADDR_W-1:0] vbr_q;
    logic              irq_q;
    logic              use_msp_q;
    logic [ADDR_W-1:0] sp_base_q;

    logic              use_msp_d;
    logic [ADDR_W-1:0] sp_base_d;
    logic [SR_W-1:0]   sr_new;
    logic [OFF_W-1:0]  offset;
    logic [ADDR_W-1:0] fetch_addr;
    logic              accept;

    logic [SR_W-1:0]   sr_out_q;
    logic              sp_sel_q;
    logic [ADDR_W-1:0] sp_out_q;
    logic [ADDR_W-1:0] vec_addr_q;

    // Handshake: ready only while idle.
    always_comb begin
        req_ready = (state_q == ST_IDLE);
        accept    = req_valid && req_ready;
    end

    exc_stack_sel u_stack_sel (
        .is_irq   (req_is_irq),
        .mstk_bit (sr_in[SR_MSTK_BIT]),
        .msp      (msp_in),
        .isp      (isp_in),
        .use_msp  (use_msp_d),
        .sp_base  (sp_base_d)
    );

    exc_sr_update u_sr_update (
        .sr_copy (sr_copy_q),
        .is_irq  (irq_q),
        .sr_new  (sr_new)
    );

    exc_vector_calc #(.VEC_W(VEC_W)) u_vector_calc (
        .vec_num    (vec_q),
        .vbr        (vbr_q),
        .offset     (offset),
        .fetch_addr (fetch_addr)
    );

    exc_frame_gen #(.VEC_W(VEC_W)) u_frame_gen (
        .state   (state_q),
        .sp_base (sp_base_q),
        .sr_copy (sr_copy_q),
        .pc      (pc_q),
        .offset  (offset),
        .wr_en   (wr_en),
        .wr_addr (wr_addr),
        .wr_data (wr_data)
    );

    // Sequence state: idle -> write high word -> write low word -> done.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            state_q <= ST_IDLE;
        end else begin
            case (state_q)
                ST_IDLE:  if (accept) state_q <= ST_WR_HI;
                ST_WR_HI: state_q <= ST_WR_LO;
                ST_WR_LO: state_q <= ST_DONE;
                default:  state_q <= ST_IDLE;
            endcase
        end
    end

    // Capture status copy, vector and stack choice on acceptance.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            sr_copy_q <= '0;
            vec_q     <= '0;
            pc_q      <= '0;
            vbr_q     <= '0;
            irq_q     <= 1'b0;
            use_msp_q <= 1'b0;
            sp_base_q <= '0;
        end else if (accept) begin
            sr_copy_q <= sr_in;
            vec_q     <= req_vector;
            pc_q      <= req_pc;
            vbr_q     <= vbr_in;
            irq_q     <= req_is_irq;
            use_msp_q <= use_msp_d;
            sp_base_q <= sp_base_d;
        end
    end

    // Load the result registers as the last write completes.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            sr_out_q   <= '0;
            sp_sel_q   <= 1'b0;
            sp_out_q   <= '0;
            vec_addr_q <= '0;
        end else if (state_q == ST_WR_LO) begin
            sr_out_q   <= sr_new;
            sp_sel_q   <= use_msp_q;
            sp_out_q   <= sp_base_q - ADDR_W'(2 * FRAME_STEP);
            vec_addr_q <= fetch_addr;
        end
    end

    // Drive the result ports from their registers.
    always_comb begin
        sr_out     = sr_out_q;
        sp_sel_out = sp_sel_q;
        sp_out     = sp_out_q;
        vec_addr   = vec_addr_q;
        done       = (state_q == ST_DONE);
    end
endmodule

// File: rtl/exc_entry_chk.sv
// Port-level property checker for the exception entry sequencer.
// Assumes: reset is held for at least one clock before use.
module exc_entry_chk (
    input logic        clk,
    input logic        rst_n,
    input logic        req_valid,
    input logic        req_ready,
    input logic        wr_en,
    input logic [31:0] wr_addr,
    input logic        done,
    input logic [15:0] sr_out,
    input logic [31:0] sp_out
);
    // R2: no new request while a frame is in flight.
    assert_busy_holdoff_R2: assert property (@(posedge clk) disable iff (!rst_n)
        (wr_en || done) |-> !req_ready);

    // R3: the first write follows the acceptance edge.
    assert_accept_write_R3: assert property (@(posedge clk) disable iff (!rst_n)
        (req_valid && req_ready) |=> wr_en);

    // R5: back-to-back writes step down by four.
    assert_predec_R5: assert property (@(posedge clk) disable iff (!rst_n)
        (wr_en && $past(wr_en)) |-> (wr_addr == $past(wr_addr) - 32'd4));

    // R8: done lasts one cycle.
    assert_done_pulse_R8: assert property (@(posedge clk) disable iff (!rst_n)
        done |=> !done);

    // R8: done comes directly after a write and carries none itself.
    assert_done_after_write_R8: assert property (@(posedge clk) disable iff (!rst_n)
        done |-> ($past(wr_en) && !wr_en));

    // R9: entry always ends in supervisor state.
    assert_supervisor_R9: assert property (@(posedge clk) disable iff (!rst_n)
        done |-> sr_out[13]);

    // R10: new stack pointer equals the last frame word address.
    assert_new_sp_R10: assert property (@(posedge clk) disable iff (!rst_n)
        done |-> (sp_out == $past(wr_addr)));
endmodule

bind exc_entry_seq exc_entry_chk i_exc_entry_chk (
    .clk       (clk),
    .rst_n     (rst_n),
    .req_valid (req_valid),
    .req_ready (req_ready),
    .wr_en     (wr_en),
    .wr_addr   (wr_addr),
    .done      (done),
    .sr_out    (sr_out),
    .sp_out    (sp_out)
);

// File: tb/test_exc_entry_seq.sv
// Self-checking bench: seeded random and directed exception entries.
module test_exc_entry_seq;
    localparam int CLK_PERIOD = 10;

    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        req_valid = 1'b0;
    logic        req_ready;
    logic [7:0]  req_vector = '0;
    logic        req_is_irq = 1'b0;
    logic [31:0] req_pc = '0;
    logic [15:0] sr_in = '0;
    logic [31:0] vbr_in = '0;
    logic [31:0] msp_in = '0;
    logic [31:0] isp_in = '0;
    logic        wr_en;
    logic [31:0] wr_addr;
    logic [31:0] wr_data;
    logic [15:0] sr_out;
    logic        sp_sel_out;
    logic [31:0] sp_out;
    logic [31:0] vec_addr;
    logic        done;

    int n_tests = 0;
    int n_fail  = 0;

    always #(CLK_PERIOD / 2) clk = ~clk;

    exc_entry_seq i_exc_entry_seq (
        .clk(clk), .rst_n(rst_n), .req_valid(req_valid), .req_ready(req_ready),
        .req_vector(req_vector), .req_is_irq(req_is_irq), .req_pc(req_pc),
        .sr_in(sr_in), .vbr_in(vbr_in), .msp_in(msp_in), .isp_in(isp_in),
        .wr_en(wr_en), .wr_addr(wr_addr), .wr_data(wr_data), .sr_out(sr_out),
        .sp_sel_out(sp_sel_out), .sp_out(sp_out), .vec_addr(vec_addr), .done(done)
    );

    task automatic chk(input bit ok, input string tag, input logic [31:0] act,
                       input logic [31:0] exp);
        n_tests++;
        if (!ok) begin
            n_fail++;
            $display("FAIL %s actual=%h expected=%h", tag, act, exp);
        end
    endtask

    function automatic logic [15:0] exp_sr(input logic [15:0] sr, input logic irq);
        logic [15:0] r;
        r = sr;
        r[13] = 1'b1;
        if (irq) r[12] = 1'b0;
        return r;
    endfunction

    function automatic logic [31:0] exp_word2(input logic [31:0] pc, input logic [7:0] v);
        return {pc[31:16], 6'b0, v, 2'b00};
    endfunction

    task automatic run_req(input logic [7:0] v, input logic irq, input logic [31:0] pc,
                           input logic [15:0] sr, input logic [31:0] vbr,
                           input logic [31:0] msp, input logic [31:0] isp,
                           input bit noise);
        logic        use_m;
        logic [31:0] base;
        logic [15:0] sr_exp;
        logic [31:0] va_exp;
        use_m  = !irq && sr[12];
        base   = use_m ? msp : isp;
        sr_exp = exp_sr(sr, irq);
        va_exp = vbr + {22'b0, v, 2'b00};
        @(negedge clk);
        req_vector = v; req_is_irq = irq; req_pc = pc; sr_in = sr;
        vbr_in = vbr; msp_in = msp; isp_in = isp; req_valid = 1'b1;
        chk(req_ready == 1'b1, "R2 ready while idle", 32'(req_ready), 32'd1);
        @(negedge clk);
        if (noise) begin
            req_vector = 8'($urandom); req_is_irq = 1'($urandom);
            req_pc = $urandom; sr_in = 16'($urandom); vbr_in = $urandom;
            msp_in = $urandom; isp_in = $urandom;
        end else begin
            req_valid = 1'b0;
        end
        chk(req_ready == 1'b0, "R2 busy after accept", 32'(req_ready), 32'd0);
        chk(wr_en == 1'b1, "R3 first write strobe", 32'(wr_en), 32'd1);
        chk(wr_addr == base - 32'd4, "R5 first address", wr_addr, base - 32'd4);
        chk(wr_data == {sr, pc[15:0]}, "R6 first word", wr_data, {sr, pc[15:0]});
        @(negedge clk);
        chk(wr_en == 1'b1, "R3 second write strobe", 32'(wr_en), 32'd1);
        chk(wr_addr == base - 32'd8, "R5 second address", wr_addr, base - 32'd8);
        chk(wr_data == exp_word2(pc, v), "R7 second word", wr_data, exp_word2(pc, v));
        @(negedge clk);
        req_valid = 1'b0;
        chk(done == 1'b1, "R8 done pulse", 32'(done), 32'd1);
        chk(wr_en == 1'b0, "R3 no write at done", 32'(wr_en), 32'd0);
        chk(req_ready == 1'b0, "R2 busy at done", 32'(req_ready), 32'd0);
        chk(vec_addr == va_exp, "R8 vector address", vec_addr, va_exp);
        chk(sr_out == sr_exp, "R9 new status", 32'(sr_out), 32'(sr_exp));
        chk(sp_sel_out == use_m, "R4 stack select", 32'(sp_sel_out), 32'(use_m));
        chk(sp_out == base - 32'd8, "R10 new stack pointer", sp_out, base - 32'd8);
        @(negedge clk);
        chk(done == 1'b0, "R8 done one cycle", 32'(done), 32'd0);
        chk(req_ready == 1'b1, "R2 ready again", 32'(req_ready), 32'd1);
        chk(sp_out == base - 32'd8 && sr_out == sr_exp, "R10 results held",
            sp_out, base - 32'd8);
    endtask

    // Main stimulus: reset, directed corners, then seeded random entries.
    initial begin
        void'($urandom(32'd20240607));
        repeat (4) @(negedge clk);
        chk(req_ready == 1'b1 && wr_en == 1'b0 && done == 1'b0, "R1 handshake in reset",
            {29'b0, req_ready, wr_en, done}, 32'h4);
        rst_n = 1'b1;
        @(negedge clk);
        chk(req_ready == 1'b1 && wr_en == 1'b0 && done == 1'b0, "R1 idle after reset",
            {29'b0, req_ready, wr_en, done}, 32'h4);
        chk(sr_out == 16'h0 && sp_out == 32'h0 && vec_addr == 32'h0 && sp_sel_out == 1'b0,
            "R1 results cleared", sp_out | vec_addr | 32'(sr_out), 32'h0);
        // R4: task exception with mode bit set uses master stack
        run_req(8'd5, 1'b0, 32'h1234_5678, 16'h1700, 32'h0000_1000,
                32'h0008_0000, 32'h0004_0000, 1'b0);
        // R9: interrupt with mode bit set clears it and uses interrupt stack
        run_req(8'd26, 1'b1, 32'hCAFE_0102, 16'h1504, 32'h0000_2000,
                32'h0008_0000, 32'h0004_0000, 1'b1);
        // R4: task exception with mode bit clear uses interrupt stack
        run_req(8'd0, 1'b0, 32'h0000_0000, 16'h0000, 32'h0,
                32'h0008_0000, 32'h0004_0000, 1'b0);
        // R8: highest vector with table base near top wraps the address
        run_req(8'd255, 1'b0, 32'hFFFF_FFFF, 16'hFFFF, 32'hFFFF_FFF0,
                32'h0000_0010, 32'h0000_0100, 1'b1);
        // R5: master stack at zero wraps on predecrement
        run_req(8'd9, 1'b0, 32'h8000_0000, 16'h3000, 32'h0,
                32'h0000_0000, 32'h0000_0040, 1'b0);
        for (int i = 0; i < 40; i++) begin
            run_req(8'($urandom), 1'($urandom), $urandom, 16'($urandom), $urandom,
                    $urandom, $urandom, 1'($urandom));
        end
        $display("  [TB] %0d tests run, %0d failed", n_tests, n_fail);
        $finish;
    end

    // Watchdog: a hung run is a failure and still reaches the summary.
    initial begin
        repeat (200000) @(posedge clk);
        n_tests++;
        n_fail++;
        $display("FAIL R2 watchdog expired actual=hung expected=finished");
        $display("  [TB] %0d tests run, %0d failed", n_tests, n_fail);
        $finish;
    end
endmodule